// File: doc/BRIEF.md
# Bank-Isolated Block Transfer Engine

This block moves blocks of words between an I/O stream and main memory without ever taking a bus cycle from the processor. Main memory is split into several banks, and each bank has its own segment of address, data and control wires. A bank-ownership register, written by software, decides which segments are cut away from the processor and handed to the transfer engine. Each segment carries traffic from only one master at a time, and no access spans two segments.

Software first assigns a bank to the engine through the ownership register. It then issues a descriptor that gives the bank, the starting word address, the length in words and the direction. While the engine streams words through a valid/ready handshake, the processor keeps single-cycle access to every bank it still owns. An access to an engine-owned bank gets an error response at once and does not wait. The engine refreshes its own bank at fixed points in its sequence. It reports completion through a done flag and a word count.

Top module: `segbus_dma`

## Requirements
- R1: After reset, `dma_done` is 0, `dma_count` is 0, every bank is owned by the processor, and `bank_en`, `bank_ref`, `cpu_ack`, `cpu_err`, `io_in_ready` and `io_out_valid` are all 0.
- R2: A processor request to a bank whose `seg_mask` bit is 0 drives that bank in the same cycle. It is answered one cycle later with `cpu_ack`=1 and `cpu_err`=0. For a read, `cpu_rdata` holds the stored word in that same response cycle.
- R3: A processor request to a bank whose `seg_mask` bit is 1 is answered one cycle later with `cpu_err`=1 and `cpu_ack`=0. The request raises no `bank_en` on that bank.
- R4: A write to the ownership register (`seg_wr`) takes effect only while no transfer is active. A write made during a transfer is dropped, and ownership afterwards is unchanged.
- R5: A descriptor (`desc_valid`) starts a transfer only if the engine is idle, `desc_len` is nonzero and the named bank has its ownership bit set. Any other descriptor is ignored.
- R6: With `desc_dir`=0 (stream to memory), the k-th word accepted on `io_in_valid`/`io_in_ready` is written to word address `desc_addr`+k, modulo the bank size, in the named bank.
- R7: With `desc_dir`=1 (memory to stream), the words at `desc_addr`+k, modulo the bank size, appear in order on `io_out_data` and are held while `io_out_valid` is 1 and `io_out_ready` is 0.
- R8: After every REF_EVERY-th transferred word, the engine spends one cycle with `bank_ref` high on its bank only, with no `bank_en` on that bank in that cycle. A transfer of L words produces exactly floor(L/REF_EVERY) refresh cycles.
- R9: `dma_count` clears when a transfer starts and rises by one per transferred word. `dma_done` clears on start and rises once the last word and any refresh due after it have finished, with `dma_count` equal to `desc_len`.
- R10: During a transfer the engine touches only its assigned bank. Processor accesses to other banks are answered in one cycle, as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, one cycle |
| cpu_we | input | 1 | Processor write (1) or read (0) |
| cpu_bank | input | BW | Processor target bank |
| cpu_addr | input | AW | Processor word address within bank |
| cpu_wdata | input | DW | Processor write data |
| cpu_rdata | output | DW | Processor read data, valid with cpu_ack |
| cpu_ack | output | 1 | Access completed |
| cpu_err | output | 1 | Access refused: bank owned by the engine |
| seg_wr | input | 1 | Write strobe for the ownership register |
| seg_mask | input | NBANK | Ownership value; bit b set gives bank b to the engine |
| desc_valid | input | 1 | Descriptor strobe |
| desc_bank | input | BW | Bank to transfer in |
| desc_addr | input | AW | First word address |
| desc_len | input | LW | Number of words |
| desc_dir | input | 1 | 0 stream to memory, 1 memory to stream |
| io_in_valid | input | 1 | Inbound word present |
| io_in_data | input | DW | Inbound word |
| io_in_ready | output | 1 | Engine takes inbound word |
| io_out_valid | output | 1 | Outbound word present |
| io_out_data | output | DW | Outbound word |
| io_out_ready | input | 1 | Sink takes outbound word |
| bank_en | output | NBANK | Per-bank access enable |
| bank_we | output | NBANK | Per-bank write enable |
| bank_addr | output | NBANK*AW | Per-bank address, bank b at [b*AW +: AW] |
| bank_wdata | output | NBANK*DW | Per-bank write data |
| bank_rdata | input | NBANK*DW | Per-bank read data, one cycle after a read enable |
| bank_ref | output | NBANK | Per-bank refresh strobe |
| dma_done | output | 1 | Last transfer finished |
| dma_count | output | LW | Words moved in current or last transfer |

## Verification
A corrupt ownership register shows up at the ports within one cycle. A processor access then draws an ack where an error was due, or the reverse, or lands on the engine's bank. A stuck address or word counter shows up at the first handshake after the fault, as a wrong streamed word or a write to the wrong address. A miscounted refresh counter shifts the refresh strobe off its word boundary, and the shift is seen at the end of the transfer as a wrong refresh total or a done flag raised too early.

// File: rtl/segbus_dma_pkg.sv
package segbus_dma_pkg;
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_READ,
        ENG_SEND,
        ENG_TAKE,
        ENG_REFRESH
    } eng_state_e;
endpackage

// File: rtl/segbus_owner_reg.sv
module segbus_owner_reg #(
    parameter int NBANK = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [NBANK-1:0] wr_mask,
    input  logic             xfer_busy,
    output logic [NBANK-1:0] owner_q
);
    typedef struct packed {
        logic [NBANK-1:0] mask;
    } own_t;

    own_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && !xfer_busy) st_d.mask = wr_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign owner_q = st_q.mask;

    // R4
    owner_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(xfer_busy) |-> $stable(owner_q));
endmodule

// File: rtl/segbus_cpu_port.sv
module segbus_cpu_port #(
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [BW-1:0]    bank,
    input  logic [NBANK-1:0] owner,
    output logic             grant,
    output logic             ack,
    output logic             err,
    output logic [BW-1:0]    resp_bank
);
    typedef struct packed {
        logic          ack;
        logic          err;
        logic [BW-1:0] rbank;
    } rsp_t;

    rsp_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        grant      = req && !owner[bank];
        st_d.ack   = grant;
        st_d.err   = req && owner[bank];
        if (grant) st_d.rbank = bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ack       = st_q.ack;
    assign err       = st_q.err;
    assign resp_bank = st_q.rbank;

    // R3
    ack_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && err));
    // R3
    refuse_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && owner[bank]) |=> (err && !ack));
endmodule

// File: rtl/segbus_engine.sv
module segbus_engine
    import segbus_dma_pkg::*;
#(
    parameter int NBANK     = 4,
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int LW        = 9,
    parameter int REF_EVERY = 4,
    localparam int BW  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int RCW = $clog2(REF_EVERY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BW-1:0]    start_bank,
    input  logic [AW-1:0]    start_addr,
    input  logic [LW-1:0]    start_len,
    input  logic             start_dir,
    input  logic [NBANK-1:0] owner,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_ref,
    output logic [BW-1:0]    cur_bank,
    output logic             busy,
    output logic             done,
    output logic [LW-1:0]    count
);
    typedef struct packed {
        eng_state_e     st;
        logic [BW-1:0]  bank;
        logic           dir;
        logic [AW-1:0]  addr;
        logic [LW-1:0]  rem;
        logic [LW-1:0]  len;
        logic [LW-1:0]  cnt;
        logic [RCW-1:0] rc;
        logic           done;
    } eng_t;

    eng_t st_d, st_q;
    logic word_moved;

    always_comb begin
        st_d       = st_q;
        word_moved = 1'b0;
        in_ready   = 1'b0;
        out_valid  = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_ref    = 1'b0;
        mem_addr   = st_q.addr;
        mem_wdata  = in_data;
        out_data   = mem_rdata;

        case (st_q.st)
            ENG_IDLE: begin
                if (start && (start_len != '0) && owner[start_bank]) begin
                    st_d.bank = start_bank;
                    st_d.dir  = start_dir;
                    st_d.addr = start_addr;
                    st_d.rem  = start_len;
                    st_d.len  = start_len;
                    st_d.cnt  = '0;
                    st_d.rc   = '0;
                    st_d.done = 1'b0;
                    st_d.st   = start_dir ? ENG_READ : ENG_TAKE;
                end
            end
            ENG_READ: begin
                mem_en  = 1'b1;
                st_d.st = ENG_SEND;
            end
            ENG_SEND: begin
                out_valid  = 1'b1;
                word_moved = out_ready;
            end
            ENG_TAKE: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    mem_en     = 1'b1;
                    mem_we     = 1'b1;
                    word_moved = 1'b1;
                end
            end
            ENG_REFRESH: begin
                mem_ref = 1'b1;
                if (st_q.rem == '0) begin
                    st_d.st   = ENG_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.st = st_q.dir ? ENG_READ : ENG_TAKE;
                end
            end
            default: st_d.st = ENG_IDLE;
        endcase

        if (word_moved) begin
            st_d.cnt  = st_q.cnt + LW'(1);
            st_d.addr = st_q.addr + AW'(1);
            st_d.rem  = st_q.rem - LW'(1);
            if (st_q.rc == RCW'(REF_EVERY - 1)) begin
                st_d.rc = '0;
                st_d.st = ENG_REFRESH;
            end else begin
                st_d.rc = st_q.rc + RCW'(1);
                if (st_q.rem == LW'(1)) begin
                    st_d.st   = ENG_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.st = st_q.dir ? ENG_READ : ENG_TAKE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{st: ENG_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign cur_bank = st_q.bank;
    assign busy     = (st_q.st != ENG_IDLE);
    assign done     = st_q.done;
    assign count    = st_q.cnt;

    // R9
    done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (count == st_q.len));
    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (count <= st_q.len));
    // R8
    refresh_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ref |-> !mem_en);
    // R5
    start_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> owner[cur_bank]);
endmodule

// File: rtl/segbus_dma.sv
module segbus_dma #(
    parameter int NBANK     = 4,
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int LW        = 9,
    parameter int REF_EVERY = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [BW-1:0]       cpu_bank,
    input  logic [AW-1:0]       cpu_addr,
    input  logic [DW-1:0]       cpu_wdata,
    output logic [DW-1:0]       cpu_rdata,
    output logic                cpu_ack,
    output logic                cpu_err,
    input  logic                seg_wr,
    input  logic [NBANK-1:0]    seg_mask,
    input  logic                desc_valid,
    input  logic [BW-1:0]       desc_bank,
    input  logic [AW-1:0]       desc_addr,
    input  logic [LW-1:0]       desc_len,
    input  logic                desc_dir,
    input  logic                io_in_valid,
    input  logic [DW-1:0]       io_in_data,
    output logic                io_in_ready,
    output logic                io_out_valid,
    output logic [DW-1:0]       io_out_data,
    input  logic                io_out_ready,
    output logic [NBANK-1:0]    bank_en,
    output logic [NBANK-1:0]    bank_we,
    output logic [NBANK*AW-1:0] bank_addr,
    output logic [NBANK*DW-1:0] bank_wdata,
    input  logic [NBANK*DW-1:0] bank_rdata,
    output logic [NBANK-1:0]    bank_ref,
    output logic                dma_done,
    output logic [LW-1:0]       dma_count
);
    logic [NBANK-1:0] owner;
    logic             eng_busy;
    logic             cpu_grant;
    logic [BW-1:0]    cpu_rbank;
    logic [BW-1:0]    eng_bank;
    logic             eng_en, eng_we, eng_ref;
    logic [AW-1:0]    eng_addr;
    logic [DW-1:0]    eng_wdata;
    logic [DW-1:0]    eng_rdata;

    segbus_owner_reg #(.NBANK(NBANK)) u_owner (
        .clk(clk), .rst_n(rst_n), .wr(seg_wr), .wr_mask(seg_mask),
        .xfer_busy(eng_busy), .owner_q(owner)
    );

    segbus_cpu_port #(.NBANK(NBANK)) u_cpu (
        .clk(clk), .rst_n(rst_n), .req(cpu_req), .bank(cpu_bank),
        .owner(owner), .grant(cpu_grant), .ack(cpu_ack), .err(cpu_err),
        .resp_bank(cpu_rbank)
    );

    segbus_engine #(
        .NBANK(NBANK), .AW(AW), .DW(DW), .LW(LW), .REF_EVERY(REF_EVERY)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(desc_valid), .start_bank(desc_bank),
        .start_addr(desc_addr), .start_len(desc_len), .start_dir(desc_dir),
        .owner(owner), .in_valid(io_in_valid), .in_data(io_in_data),
        .in_ready(io_in_ready), .out_valid(io_out_valid),
        .out_data(io_out_data), .out_ready(io_out_ready),
        .mem_rdata(eng_rdata), .mem_en(eng_en), .mem_we(eng_we),
        .mem_addr(eng_addr), .mem_wdata(eng_wdata), .mem_ref(eng_ref),
        .cur_bank(eng_bank), .busy(eng_busy), .done(dma_done),
        .count(dma_count)
    );

    assign eng_rdata = bank_rdata[eng_bank*DW +: DW];
    assign cpu_rdata = bank_rdata[cpu_rbank*DW +: DW];

    for (genvar b = 0; b < NBANK; b++) begin : g_seg
        logic eng_sel, cpu_sel;
        assign eng_sel = eng_busy && (eng_bank == BW'(b));
        assign cpu_sel = cpu_grant && (cpu_bank == BW'(b));

        assign bank_en[b]               = eng_sel ? eng_en : cpu_sel;
        assign bank_we[b]               = eng_sel ? eng_we : (cpu_sel && cpu_we);
        assign bank_addr[b*AW +: AW]    = eng_sel ? eng_addr : cpu_addr;
        assign bank_wdata[b*DW +: DW]   = eng_sel ? eng_wdata : cpu_wdata;
        assign bank_ref[b]              = eng_sel && eng_ref;

        // R10
        single_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(eng_sel && cpu_sel));
        // R10
        eng_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eng_sel |-> owner[b]);
    end
endmodule

// File: tb/tb_segbus_dma.sv
module tb_segbus_dma;
    localparam int NB = 4, AW = 8, DW = 16, LW = 9, RE = 4;
    localparam int BW = 2;

    logic clk = 0, rst_n = 0;
    always #2 clk = ~clk;

    logic cpu_req = 0, cpu_we = 0;
    logic [BW-1:0] cpu_bank = '0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
    logic cpu_ack, cpu_err;
    logic seg_wr = 0;
    logic [NB-1:0] seg_mask = '0;
    logic desc_valid = 0, desc_dir = 0;
    logic [BW-1:0] desc_bank = '0;
    logic [AW-1:0] desc_addr = '0;
    logic [LW-1:0] desc_len = '0;
    logic io_in_valid = 0, io_in_ready, io_out_valid, io_out_ready = 0;
    logic [DW-1:0] io_in_data = '0, io_out_data;
    logic [NB-1:0] bank_en, bank_we, bank_ref;
    logic [NB*AW-1:0] bank_addr;
    logic [NB*DW-1:0] bank_wdata, bank_rdata;
    logic dma_done;
    logic [LW-1:0] dma_count;

    segbus_dma #(.NBANK(NB), .AW(AW), .DW(DW), .LW(LW), .REF_EVERY(RE)) dut (.*);

    // behavioural banks
    logic [DW-1:0] mem [NB][1<<AW];
    int ref_cnt [NB];
    int clash_cnt = 0;
    always @(posedge clk) begin
        for (int b = 0; b < NB; b++) begin
            if (bank_en[b] && bank_we[b])
                mem[b][bank_addr[b*AW +: AW]] <= bank_wdata[b*DW +: DW];
            if (bank_en[b] && !bank_we[b])
                bank_rdata[b*DW +: DW] <= mem[b][bank_addr[b*AW +: AW]];
            if (bank_ref[b]) ref_cnt[b] <= ref_cnt[b] + 1;
            if (bank_ref[b] && bank_en[b]) clash_cnt <= clash_cnt + 1;
        end
    end

    int checks = 0, errors = 0;
    logic [DW-1:0] exp_q [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor for outbound stream
    always @(negedge clk) begin
        if (rst_n && io_out_valid && io_out_ready) begin
            if (exp_q.size() == 0) chk("R7 unexpected word", {16'h0, io_out_data}, 32'hffff_ffff);
            else chk("R7 stream word", {16'h0, io_out_data}, {16'h0, exp_q.pop_front()});
        end
    end

    // sink ready pattern
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 io_out_ready <= (cyc % 3) != 1;
    end

    task automatic cpu_acc(input logic we, input int b, input int a, input logic [DW-1:0] d,
                           output logic ack, output logic err, output logic [DW-1:0] rd,
                           output logic en_seen);
        @(posedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_bank = BW'(b); cpu_addr = AW'(a); cpu_wdata = d;
        #1 en_seen = bank_en[b];
        @(posedge clk); #1;
        cpu_req = 0; cpu_we = 0;
        ack = cpu_ack; err = cpu_err; rd = cpu_rdata;
    endtask

    task automatic seg_set(input logic [NB-1:0] m);
        @(posedge clk); #1; seg_wr = 1; seg_mask = m;
        @(posedge clk); #1; seg_wr = 0;
    endtask

    task automatic desc_go(input int b, input int a, input int len, input logic dir);
        @(posedge clk); #1;
        desc_valid = 1; desc_bank = BW'(b); desc_addr = AW'(a); desc_len = LW'(len); desc_dir = dir;
        @(posedge clk); #1; desc_valid = 0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!dma_done && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic feed(input int len);
        for (int i = 0; i < len; i++) begin
            if (i % 3 == 2) begin io_in_valid = 0; @(posedge clk); #1; end
            io_in_valid = 1; io_in_data = DW'(16'h1000 + i);
            do @(negedge clk); while (!io_in_ready);
            @(posedge clk); #1;
        end
        io_in_valid = 0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic ack, err, en;
        logic [DW-1:0] rd;
        int r1_before;
        for (int b = 0; b < NB; b++) begin
            ref_cnt[b] = 0;
            for (int a = 0; a < (1 << AW); a++) mem[b][a] = DW'(b * 4096 + a * 7);
        end
        bank_rdata = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", dma_done, 0);
        chk("R1 count", dma_count, 0);
        chk("R1 bank_en", bank_en, 0);
        chk("R1 bank_ref", bank_ref, 0);
        chk("R1 ack/err", {cpu_ack, cpu_err}, 0);
        chk("R1 handshakes", {io_in_ready, io_out_valid}, 0);
        cpu_acc(0, 1, 9, 0, ack, err, rd, en);
        chk("R1 bank1 owned by cpu", {ack, err}, 2'b10);

        // R2 processor access to own banks
        cpu_acc(1, 0, 5, 16'hBEEF, ack, err, rd, en);
        chk("R2 write ack", {ack, err}, 2'b10);
        chk("R2 write enable same cycle", en, 1);
        cpu_acc(0, 0, 5, 0, ack, err, rd, en);
        chk("R2 read ack", {ack, err}, 2'b10);
        chk("R2 read data", rd, 16'hBEEF);
        cpu_acc(0, 2, 255, 0, ack, err, rd, en);
        chk("R2 read preload", rd, DW'(2 * 4096 + 255 * 7));

        // R5 descriptor to a bank not given to the engine
        desc_go(1, 0, 5, 1);
        repeat (3) @(negedge clk);
        chk("R5 unowned start ignored", {io_out_valid, io_in_ready, dma_done}, 0);

        // R3 ownership and refusal
        seg_set(4'b0010);
        cpu_acc(1, 1, 0, 16'h5555, ack, err, rd, en);
        chk("R3 write refused", {ack, err}, 2'b01);
        chk("R3 no bank enable", en, 0);
        chk("R3 bank untouched", mem[1][0], DW'(4096));
        cpu_acc(0, 1, 3, 0, ack, err, rd, en);
        chk("R3 read refused", {ack, err}, 2'b01);

        // R5 zero length ignored
        desc_go(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R5 zero length ignored", {io_in_ready, dma_done}, 0);

        // R6 stream to memory with wrap, R4/R5/R10 during transfer
        r1_before = ref_cnt[1];
        desc_go(1, 250, 10, 0);
        fork
            feed(10);
            begin
                seg_set(4'b0100);                 // R4 rejected while busy
                desc_go(1, 0, 3, 1);              // R5 start while busy ignored
                cpu_acc(0, 0, 5, 0, ack, err, rd, en);
                chk("R10 concurrent ack", {ack, err}, 2'b10);
                chk("R10 concurrent data", rd, 16'hBEEF);
            end
        join
        wait_done();
        chk("R9 done after write stream", dma_done, 1);
        chk("R9 count write stream", dma_count, 10);
        chk("R8 refresh count write", ref_cnt[1] - r1_before, 10 / RE);
        for (int i = 0; i < 10; i++)
            chk("R6 stored word", mem[1][(250 + i) % 256], DW'(16'h1000 + i));
        chk("R6 below start untouched", mem[1][249], DW'(4096 + 249 * 7));
        chk("R6 past end untouched", mem[1][4], DW'(4096 + 4 * 7));
        repeat (4) @(negedge clk);
        chk("R5 busy start dropped", io_out_valid, 0);
        cpu_acc(0, 1, 3, 0, ack, err, rd, en);
        chk("R4 bank1 still engine owned", {ack, err}, 2'b01);
        cpu_acc(0, 2, 3, 0, ack, err, rd, en);
        chk("R4 bank2 still cpu owned", {ack, err}, 2'b10);

        // R7 memory to stream, length not a multiple of REF_EVERY
        r1_before = ref_cnt[1];
        for (int i = 0; i < 9; i++) exp_q.push_back(mem[1][3 + i]);
        desc_go(1, 3, 9, 1);
        chk("R9 done cleared on start", dma_done, 0);
        wait_done();
        chk("R9 done read stream", dma_done, 1);
        chk("R9 count read stream", dma_count, 9);
        chk("R7 all words streamed", exp_q.size(), 0);
        chk("R8 refresh count read", ref_cnt[1] - r1_before, 9 / RE);

        // R8 length a multiple of REF_EVERY, refresh before done
        r1_before = ref_cnt[1];
        for (int i = 0; i < 8; i++) exp_q.push_back(mem[1][(252 + i) % 256]);
        desc_go(1, 252, 8, 1);
        wait_done();
        chk("R8 refresh on multiple", ref_cnt[1] - r1_before, 2);
        chk("R9 count multiple", dma_count, 8);
        chk("R7 wrap words streamed", exp_q.size(), 0);
        chk("R8 refresh only engine bank", ref_cnt[0] + ref_cnt[2] + ref_cnt[3], 0);
        chk("R8 refresh never with enable", clash_cnt, 0);

        // R4 idle write takes effect
        seg_set(4'b0000);
        cpu_acc(1, 1, 7, 16'h7777, ack, err, rd, en);
        chk("R4 idle release", {ack, err}, 2'b10);
        summary();
    end
endmodule